// File: doc/BRIEF.md
# SPI NOR Command Engine

This block runs one short command on a serial NOR flash each time software triggers it. Software first writes the opcode, a payload byte count, a chip-select number with a dummy byte count, and a 24-bit flash address. It then writes an operation word. Each bit of that word switches one phase of the command on. The engine runs the enabled phases in a fixed order: opcode, address, dummy, write payload, read payload, and last a status poll. It drives a serial clock, one active-low select line per device, and a single data line in each direction.

Payload bytes pass through a 64-byte window buffer. The host reaches this buffer through its own port, separate from the register port. For a program command, software fills the window before the trigger. After a read command, the received bytes sit in the window from offset 0 upward. When the command is complete and its select line has been released, a sticky done flag rises. The flag stays high until software writes a one to the clear register.

Register word addresses are: 0 opcode, 1 byte count, 2 select/dummy, 3 timing, 4 flash address, 5 status (read only), 6 clear, 7 operation word. Register reads are combinational.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, all select lines are high and the serial clock is low. The done output is 0. The timing register (address 3) reads 0x66F, which means hold 6 in [11:8], setup 6 in [7:4] and deselect gap 15 in [3:0].
- R2: With a byte count of 0 and only the opcode bit (bit 7) plus start (bit 0) set in the operation word, exactly one byte is sent. That byte is the opcode from bits [7:0] of register 0, and it takes 8 clock pulses.
- R3: The interface uses SPI mode 0. The clock idles low. Output data is stable while the clock is high. Bytes are shifted most significant bit first.
- R4: Bit 6 of the operation word adds three address bytes (register 4, high byte first) after the opcode. Bit 8 adds N dummy bytes of 0x00, where N is bits [3:0] of register 2. The dummy bytes are sent after the address.
- R5: Bit 5 of the operation word sends window bytes 0 up to count-1, after the address and dummy bytes.
- R6: Bit 2 of the operation word clocks in count bytes and stores them in the window starting at offset 0.
- R7: A byte count above 64 (register 1, bits [13:0]) is treated as 64.
- R8: Bit 1 of the operation word adds a status poll. The engine keeps reading bytes while the last byte received has bit 0 set. The final byte is stored at window offset 0.
- R9: The device is chosen by bit 11 of register 2, and only that device's select line goes low.
- R10: From the select line falling to the first clock rise, the time grows by one cycle per unit of the setup field. The time from the last clock fall to the select line rising grows likewise with the hold field. The time from the select line rising to done rising grows likewise with the gap field.
- R11: The done flag (status bit 0 and `op_done`) rises only after the select line has been released. It stays set until a write to address 6 with bit 0 set.
- R12: While an operation runs (status bit 1), a new start and writes to the configuration registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| win_we | input | 1 | Window byte write strobe |
| win_addr | input | 6 | Window byte offset |
| win_wdata | input | 8 | Window write byte |
| win_rdata | output | 8 | Window read byte |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 2 | Active-low device selects |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| op_done | output | 1 | Sticky done flag |

## Verification
The hardest case to reach is a status poll that has to repeat. It happens only when the flash returns a status byte with bit 0 set, so the bench's flash model serves a scripted response list in which two busy bytes come before a ready byte. The bench then checks both the byte count on the wire and the value left in the window. The ignored-start case needs a second trigger that lands while the first command is still clocking. The bench issues that trigger a fixed number of cycles after the first one and then checks the wire log and the readback of the opcode register.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  localparam logic [2:0] A_CMD    = 3'd0;
  localparam logic [2:0] A_COUNT  = 3'd1;
  localparam logic [2:0] A_SEL    = 3'd2;
  localparam logic [2:0] A_TIMING = 3'd3;
  localparam logic [2:0] A_ADDR   = 3'd4;
  localparam logic [2:0] A_STATUS = 3'd5;
  localparam logic [2:0] A_CLEAR  = 3'd6;
  localparam logic [2:0] A_OP     = 3'd7;

  localparam int OPB_START  = 0;
  localparam int OPB_STATUS = 1;
  localparam int OPB_READ   = 2;
  localparam int OPB_WRITE  = 5;
  localparam int OPB_ADDR   = 6;
  localparam int OPB_OPC    = 7;
  localparam int OPB_DUMMY  = 8;
  localparam int SEL_CS_LSB = 11;

  localparam int NUM_PH = 6;
  typedef enum logic [2:0] {
    PH_OPC = 3'd0, PH_ADR = 3'd1, PH_DUM = 3'd2,
    PH_WR  = 3'd3, PH_RD  = 3'd4, PH_ST  = 3'd5, PH_NONE = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_XFER, S_HOLD, S_GAP
  } seq_e;
endpackage

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
module spi_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done
);
  logic [7:0] sh_tx, sh_rx;
  logic [2:0] bit_q;
  logic       half_q, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tx  <= '0;
      sh_rx  <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (go && !act_q) begin
      act_q  <= 1'b1;
      sh_tx  <= tx_byte;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else if (act_q) begin
      if (!half_q) begin
        half_q <= 1'b1;
        sh_rx  <= {sh_rx[6:0], miso};
      end else begin
        half_q <= 1'b0;
        sh_tx  <= {sh_tx[6:0], 1'b0};
        if (bit_q == 3'd7) act_q <= 1'b0;
        else               bit_q <= bit_q + 3'd1;
      end
    end
  end

  assign sclk    = act_q & half_q;
  assign mosi    = sh_tx[7];
  assign rx_byte = sh_rx;
  assign done    = act_q & half_q & (bit_q == 3'd7);
endmodule

// File: rtl/spi_cmd_window.sv
`timescale 1ns/1ps
module spi_cmd_window #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (eng_we)       mem[eng_addr]  <= eng_wdata;
    else if (host_we) mem[host_addr] <= host_wdata;
  end

  assign host_rdata = mem[host_addr];
  assign eng_rdata  = mem[eng_addr];
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int WIN_BYTES  = 64,
  parameter int NUM_CS     = 2,
  parameter int CNT_W      = 14,
  parameter int ADDR_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [2:0]                   reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic                         win_we,
  input  logic [$clog2(WIN_BYTES)-1:0] win_addr,
  input  logic [7:0]                   win_wdata,
  output logic [7:0]                   win_rdata,
  output logic                         spi_sclk,
  output logic [NUM_CS-1:0]            spi_cs_n,
  output logic                         spi_mosi,
  input  logic                         spi_miso,
  output logic                         op_done
);
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int ADR_W  = 8 * ADDR_BYTES;

  seq_e               state_q;
  phase_e             cur_q, first_ph, next_ph;
  logic [NUM_PH-1:0]  ph_en_q, live;
  logic [CNT_W-1:0]   ph_len [NUM_PH];
  logic [CNT_W-1:0]   count_q, eff_cnt, left_q, idx_q;
  logic [7:0]         opcode_q, tx_byte, rx_byte, eng_rdata;
  logic [CS_W-1:0]    cs_q, cs_act_q;
  logic [3:0]         dummy_q, t_hold_q, t_setup_q, t_gap_q, tmr_q;
  logic [ADR_W-1:0]   addr_q, adr_sh;
  logic               done_q, cs_on_q, inflight_q, busy, go, sh_done;
  logic               start_req, cfg_we, clr_req, eng_we;
  logic [WIN_AW-1:0]  eng_addr;

  assign busy      = (state_q != S_IDLE);
  assign start_req = reg_we && reg_addr == A_OP && reg_wdata[OPB_START] && !busy;
  assign cfg_we    = reg_we && !busy;
  assign clr_req   = reg_we && reg_addr == A_CLEAR && reg_wdata[0];
  assign eff_cnt   = (count_q > CNT_W'(WIN_BYTES)) ? CNT_W'(WIN_BYTES) : count_q;

  always_comb begin
    ph_len[PH_OPC] = CNT_W'(1);
    ph_len[PH_ADR] = CNT_W'(ADDR_BYTES);
    ph_len[PH_DUM] = CNT_W'(dummy_q);
    ph_len[PH_WR]  = eff_cnt;
    ph_len[PH_RD]  = eff_cnt;
    ph_len[PH_ST]  = CNT_W'(1);
    first_ph = PH_NONE;
    next_ph  = PH_NONE;
    for (int p = NUM_PH - 1; p >= 0; p--) begin
      live[p] = ph_en_q[p] && (ph_len[p] != '0);
      if (live[p]) first_ph = phase_e'(p);
      if (live[p] && p > int'(cur_q)) next_ph = phase_e'(p);
    end
  end

  always_comb begin
    adr_sh = addr_q << {idx_q, 3'b000};
    unique case (cur_q)
      PH_OPC:  tx_byte = opcode_q;
      PH_ADR:  tx_byte = adr_sh[ADR_W-1 -: 8];
      PH_WR:   tx_byte = eng_rdata;
      default: tx_byte = 8'h00;
    endcase
  end

  assign go       = (state_q == S_XFER) && !inflight_q;
  assign eng_we   = sh_done && (state_q == S_XFER) && (cur_q == PH_RD || cur_q == PH_ST);
  assign eng_addr = (cur_q == PH_ST) ? '0 : idx_q[WIN_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q  <= '0;
      count_q   <= '0;
      cs_q      <= '0;
      dummy_q   <= '0;
      addr_q    <= '0;
      t_hold_q  <= 4'd6;
      t_setup_q <= 4'd6;
      t_gap_q   <= 4'd15;
    end else if (cfg_we) begin
      unique case (reg_addr)
        A_CMD:    opcode_q <= reg_wdata[7:0];
        A_COUNT:  count_q  <= reg_wdata[CNT_W-1:0];
        A_SEL:    begin
                    cs_q    <= reg_wdata[SEL_CS_LSB +: CS_W];
                    dummy_q <= reg_wdata[3:0];
                  end
        A_TIMING: {t_hold_q, t_setup_q, t_gap_q} <= reg_wdata[11:0];
        A_ADDR:   addr_q   <= reg_wdata[ADR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cur_q      <= PH_NONE;
      ph_en_q    <= '0;
      left_q     <= '0;
      idx_q      <= '0;
      tmr_q      <= '0;
      cs_on_q    <= 1'b0;
      cs_act_q   <= '0;
      inflight_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (clr_req) done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_req) begin
          state_q  <= S_SETUP;
          tmr_q    <= t_setup_q;
          cs_on_q  <= 1'b1;
          cs_act_q <= cs_q;
          ph_en_q  <= {reg_wdata[OPB_STATUS], reg_wdata[OPB_READ], reg_wdata[OPB_WRITE],
                       reg_wdata[OPB_DUMMY], reg_wdata[OPB_ADDR], reg_wdata[OPB_OPC]};
        end
        S_SETUP: if (tmr_q == '0) begin
          if (first_ph == PH_NONE) begin
            state_q <= S_HOLD;
            tmr_q   <= t_hold_q;
          end else begin
            state_q <= S_XFER;
            cur_q   <= first_ph;
            left_q  <= ph_len[first_ph];
            idx_q   <= '0;
          end
        end else tmr_q <= tmr_q - 4'd1;
        S_XFER: begin
          if (!inflight_q) inflight_q <= 1'b1;
          else if (sh_done) begin
            inflight_q <= 1'b0;
            if (cur_q == PH_ST && rx_byte[0]) begin
              left_q <= left_q;
            end else if (left_q == CNT_W'(1)) begin
              if (next_ph == PH_NONE) begin
                state_q <= S_HOLD;
                tmr_q   <= t_hold_q;
              end else begin
                cur_q  <= next_ph;
                left_q <= ph_len[next_ph];
                idx_q  <= '0;
              end
            end else begin
              left_q <= left_q - CNT_W'(1);
              idx_q  <= idx_q + CNT_W'(1);
            end
          end
        end
        S_HOLD: if (tmr_q == '0) begin
          cs_on_q <= 1'b0;
          state_q <= S_GAP;
          tmr_q   <= t_gap_q;
        end else tmr_q <= tmr_q - 4'd1;
        S_GAP: if (tmr_q == '0) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end else tmr_q <= tmr_q - 4'd1;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
    assign spi_cs_n[i] = !(cs_on_q && cs_act_q == CS_W'(i));
  end

  always_comb begin
    unique case (reg_addr)
      A_CMD:    reg_rdata = {24'd0, opcode_q};
      A_COUNT:  reg_rdata = 32'(count_q);
      A_SEL:    reg_rdata = (32'(cs_q) << SEL_CS_LSB) | 32'(dummy_q);
      A_TIMING: reg_rdata = {20'd0, t_hold_q, t_setup_q, t_gap_q};
      A_ADDR:   reg_rdata = 32'(addr_q);
      A_STATUS: reg_rdata = {30'd0, busy, done_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign op_done = done_q;

  spi_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_byte(tx_byte), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx_byte), .done(sh_done)
  );

  spi_cmd_window #(.DEPTH(WIN_BYTES)) u_win (
    .clk(clk), .host_we(win_we), .host_addr(win_addr), .host_wdata(win_wdata),
    .host_rdata(win_rdata), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(rx_byte), .eng_rdata(eng_rdata)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              spi_sclk,
  input logic [NUM_CS-1:0] spi_cs_n,
  input logic              spi_mosi,
  input logic              op_done
);
  p_clock_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sclk);

  p_mosi_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  p_single_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !(reg_we && reg_addr == 3'd6 && reg_wdata[0])) |=> op_done);

  p_done_after_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_done) |-> (&spi_cs_n));

  p_select_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(&spi_cs_n) |=> ((&spi_cs_n) || $stable(spi_cs_n)));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .op_done(op_done)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        win_we = 1'b0;
  logic [5:0]  win_addr = '0;
  logic [7:0]  win_wdata = '0;
  logic [7:0]  win_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, op_done;
  logic [1:0]  spi_cs_n;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  spi_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_we(win_we),
    .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .op_done(op_done)
  );

  // flash model
  logic [7:0] resp [256];
  logic [7:0] wlog [256];
  logic [7:0] nbytes = '0;
  logic [2:0] bitn = '0;
  logic [7:0] shreg = '0;
  int rises = 0;
  logic cs_act;
  logic [1:0] cs_seen = 2'b11;
  time t_csf, t_csr, t_r1, t_lf, t_done;

  assign cs_act   = ~&spi_cs_n;
  assign spi_miso = resp[nbytes][3'd7 - bitn];

  always @(posedge spi_sclk or posedge cs_act) begin
    if (!spi_sclk) begin
      nbytes = '0; bitn = '0; rises = 0;
    end else begin
      if (rises == 0) t_r1 = $time;
      rises = rises + 1;
      shreg = {shreg[6:0], spi_mosi};
      if (bitn == 3'd7) begin
        wlog[nbytes] = shreg;
        nbytes = nbytes + 8'd1;
        bitn = '0;
      end else bitn = bitn + 3'd1;
    end
  end

  always @(cs_act) begin
    if (cs_act) begin t_csf = $time; cs_seen = spi_cs_n; end
    else t_csr = $time;
  end
  always @(negedge spi_sclk) t_lf = $time;
  always @(posedge op_done) t_done = $time;

  initial begin
    #400000;
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic win_put(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    win_we = 1'b1; win_addr = a; win_wdata = d;
    @(negedge clk);
    win_we = 1'b0;
  endtask

  task automatic win_get(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    win_addr = a;
    #1 d = win_rdata;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !op_done; i++) @(negedge clk);
  endtask

  task automatic run_op(input logic [31:0] opw);
    wr_reg(3'd7, opw);
    wait_done();
  endtask

  task automatic clear_done();
    wr_reg(3'd6, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 select lines", 32'(spi_cs_n), 32'h3);
    check("R1 sclk", 32'(spi_sclk), 32'h0);
    check("R1 done", 32'(op_done), 32'h0);
    rd_reg(3'd3, d);
    check("R1 timing reset", d, 32'h66F);
  endtask

  task automatic t_opcode_only();
    logic [31:0] d;
    wr_reg(3'd0, 32'h06); wr_reg(3'd1, 32'h0); wr_reg(3'd2, 32'h0);
    run_op(32'h81);
    check("R2 byte count", 32'(nbytes), 32'd1);
    check("R2 clock pulses", 32'(rises), 32'd8);
    check("R3 opcode msb first", 32'(wlog[0]), 32'h06);
    check("R9 device 0", 32'(cs_seen), 32'h2);
    check("R11 done set", 32'(op_done), 32'h1);
    repeat (10) @(negedge clk);
    check("R11 done sticky", 32'(op_done), 32'h1);
    clear_done();
    rd_reg(3'd5, d);
    check("R11 done cleared", d, 32'h0);
  endtask

  task automatic t_read_cs1();
    logic [7:0] b;
    wr_reg(3'd0, 32'h03); wr_reg(3'd4, 32'h123456);
    wr_reg(3'd1, 32'd4); wr_reg(3'd2, 32'h800);
    run_op(32'hC5);
    check("R9 device 1", 32'(cs_seen), 32'h1);
    check("R4 byte count", 32'(nbytes), 32'd8);
    check("R4 opcode", 32'(wlog[0]), 32'h03);
    check("R4 addr hi", 32'(wlog[1]), 32'h12);
    check("R4 addr mid", 32'(wlog[2]), 32'h34);
    check("R4 addr lo", 32'(wlog[3]), 32'h56);
    for (int k = 0; k < 4; k++) begin
      win_get(6'(k), b);
      check("R6 read window", 32'(b), 32'(resp[4 + k]));
    end
    clear_done();
  endtask

  task automatic t_dummy();
    logic [7:0] b;
    wr_reg(3'd0, 32'h0B); wr_reg(3'd4, 32'h000010);
    wr_reg(3'd1, 32'd2); wr_reg(3'd2, 32'h2);
    run_op(32'h1C5);
    check("R4 dummy byte count", 32'(nbytes), 32'd8);
    check("R4 dummy value", 32'(wlog[4]), 32'h00);
    check("R4 dummy value 2", 32'(wlog[5]), 32'h00);
    win_get(6'd0, b); check("R6 after dummy 0", 32'(b), 32'(resp[6]));
    win_get(6'd1, b); check("R6 after dummy 1", 32'(b), 32'(resp[7]));
    clear_done();
  endtask

  task automatic t_write();
    for (int k = 0; k < 5; k++) win_put(6'(k), 8'(8'h11 * (k + 1)));
    wr_reg(3'd0, 32'h02); wr_reg(3'd4, 32'h00ABCD);
    wr_reg(3'd1, 32'd5); wr_reg(3'd2, 32'h0);
    run_op(32'hE1);
    check("R5 byte count", 32'(nbytes), 32'd9);
    for (int k = 0; k < 5; k++)
      check("R5 payload", 32'(wlog[4 + k]), 32'(8'h11 * (k + 1)));
    clear_done();
  endtask

  task automatic t_clip();
    logic [7:0] b;
    wr_reg(3'd0, 32'h03); wr_reg(3'd1, 32'd100);
    run_op(32'h85);
    check("R7 clipped count", 32'(nbytes), 32'd65);
    win_get(6'd63, b);
    check("R7 last window byte", 32'(b), 32'(resp[64]));
    clear_done();
  endtask

  task automatic t_status();
    logic [7:0] b;
    resp[1] = 8'h03; resp[2] = 8'h01; resp[3] = 8'h80;
    wr_reg(3'd0, 32'h05); wr_reg(3'd1, 32'd0);
    run_op(32'h83);
    check("R8 poll bytes", 32'(nbytes), 32'd4);
    win_get(6'd0, b);
    check("R8 final status", 32'(b), 32'h80);
    clear_done();
    for (int i = 1; i < 4; i++) resp[i] = 8'(i) ^ 8'h5A;
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr_reg(3'd0, 32'h9F); wr_reg(3'd1, 32'd3);
    wr_reg(3'd7, 32'h85);
    repeat (20) @(negedge clk);
    wr_reg(3'd0, 32'h11);
    wr_reg(3'd7, 32'h81);
    wait_done();
    check("R12 first op bytes", 32'(nbytes), 32'd4);
    check("R12 first opcode", 32'(wlog[0]), 32'h9F);
    rd_reg(3'd0, d);
    check("R12 config ignored", d, 32'h9F);
    clear_done();
    repeat (200) @(negedge clk);
    check("R12 no second op", 32'(op_done), 32'h0);
  endtask

  task automatic t_timing();
    time s1, h1, g1;
    wr_reg(3'd0, 32'h06); wr_reg(3'd1, 32'd0);
    wr_reg(3'd3, 32'h123);
    run_op(32'h81);
    s1 = t_r1 - t_csf; h1 = t_csr - t_lf; g1 = t_done - t_csr;
    clear_done();
    wr_reg(3'd3, 32'h78C);
    run_op(32'h81);
    check("R10 setup delta", 32'((t_r1 - t_csf) - s1), 32'd24);
    check("R10 hold delta", 32'((t_csr - t_lf) - h1), 32'd24);
    check("R10 gap delta", 32'((t_done - t_csr) - g1), 32'd36);
    clear_done();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      resp[i] = 8'(i) ^ 8'h5A;
      wlog[i] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_opcode_only();
    t_read_cs1();
    t_dummy();
    t_write();
    t_clip();
    t_status();
    t_busy();
    t_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule